// File: doc/BRIEF.md
# Start-Bit Framed Serial Converter Port

This block is the digital serial side of a multi-channel sampling converter. A host selects the block by pulling chip-select low. It then clocks a serial clock and presents data. The block looks for the first logic one on its data input. That bit starts an 8-bit control byte. Once the whole control byte has arrived, the block picks one of several parallel sample words, using the channel field of the byte. It drives a strobe for one serial-clock period and then shifts the 10-bit sample out MSB first. The sample words stand in for the converter core, which is not modelled.

The block runs on a fast system clock with a synchronous active-high reset. It oversamples the serial clock, chip-select and data input, which must already be synchronous to the system clock. It detects the serial-clock edges itself. All outputs are registered. A host running SPI mode 0 can complete a conversion with three 8-bit transfers: one to send the control byte and two to read the result.

Top module: `sadc_port`

## Requirements
- R1: The data input is taken only on rising serial-clock edges while chip-select is low. Clock activity while chip-select is high has no effect on the next frame.
- R2: After chip-select falls, any number of zero bits is ignored. The first one taken is bit 7 (the MSB) of the control byte, and the following seven bits complete it.
- R3: The data output and the strobe change only after falling serial-clock edges. They stay constant across each rising edge.
- R4: The strobe is high for exactly one serial-clock period: from the falling edge after the 8th control bit until the next falling edge. The host therefore sees it high only at the 9th rising edge counted from the start bit.
- R5: The 10-bit result is shifted out MSB first. The host takes the MSB at the 10th rising edge and the LSB at the 19th rising edge, both counted from the start bit.
- R6: Control-byte bits 6:4 form the channel index. They select sample word i, which sits at bits i*10+9 down to i*10 of the parallel sample input.
- R7: With no leading zeros, a three-byte SPI mode 0 exchange returns second byte = {0, result[9:3]} and third byte = {result[2:0], 5'b00000}.
- R8: After the LSB, the data output is driven low until chip-select rises.
- R9: While chip-select is high, the output enable is low and the strobe is low. Reset leaves the output enable, the strobe and the data output all low.
- R10: If chip-select rises in the middle of a frame, the transfer is abandoned. The next frame hunts for a new start bit.
- R11: The selected sample is latched when the 8th control bit is taken. Later changes on the sample input do not alter the bits being shifted out.
- R12: A control byte of 0xFF selects channel 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, active low |
| sclk | input | 1 | Serial clock, synchronous to clk |
| din | input | 1 | Serial data in, taken on rising sclk |
| chan_samples | input | NUM_CH*RES_W | Parallel sample words, channel i at bits i*RES_W+:RES_W |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for dout (low means high impedance) |
| strobe | output | 1 | One-period marker before the result MSB |

## Verification
Two situations are hardest to reach from the ports. The first is a frame whose start bit does not fall on a byte boundary. The second is a frame that is cut off by chip-select and then followed by a clean one. The bench builds every frame bit by bit, so it can put a varying number of leading zeros in front of the control byte. In the aborted case it raises chip-select after a few control bits and then starts a new frame on a different channel. In a further frame the bench rewrites the selected sample after the control byte has arrived, to show that the latched value is the one shifted out.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int RES_W  = 10;
  localparam int NUM_CH = 8;
  localparam int CTRL_W = 8;
endpackage

// File: rtl/sadc_framer.sv
module sadc_framer #(
  parameter int CTRL_W = 8,
  parameter int CH_W   = 3,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rise,
  input  logic             din,
  output logic             active,
  output logic [CNT_W-1:0] cnt,
  output logic             load,
  output logic [CH_W-1:0]  chan
);
  localparam logic [CNT_W-1:0] LAST_CTRL = CNT_W'(CTRL_W - 1);

  logic [CTRL_W-2:0] shreg;
  logic [CTRL_W-1:0] byte_now;

  assign byte_now = {shreg, din};
  assign chan     = byte_now[CTRL_W-2 -: CH_W];
  assign load     = rise && active && (cnt == LAST_CTRL);

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else if (rise) begin
      if (!active) begin
        if (din) begin
          active <= 1'b1;
          cnt    <= CNT_W'(1);
          shreg  <= (CTRL_W-1)'(1);
        end
      end else begin
        shreg <= {shreg[CTRL_W-3:0], din};
        if (cnt != '1) cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(rise && din && !cs_n));

  // R10
  cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> (cnt >= $past(cnt)));
endmodule

// File: rtl/sadc_mux.sv
module sadc_mux #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int CH_W   = 3
) (
  input  logic [NUM_CH*RES_W-1:0] bus,
  input  logic [CH_W-1:0]         chan,
  output logic [RES_W-1:0]        sel
);
  logic [RES_W-1:0] slot [NUM_CH];

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_slot
    assign slot[gi] = bus[gi*RES_W +: RES_W];
  end

  assign sel = slot[chan];
endmodule

// File: rtl/sadc_tx.sv
module sadc_tx #(
  parameter int RES_W  = 10,
  parameter int CTRL_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             fall,
  input  logic             load,
  input  logic [RES_W-1:0] load_data,
  input  logic [CNT_W-1:0] cnt,
  output logic             dout,
  output logic             dout_oe,
  output logic             strobe
);
  localparam logic [CNT_W-1:0] STB_AT   = CNT_W'(CTRL_W);
  localparam logic [CNT_W-1:0] FIRST_AT = CNT_W'(CTRL_W + 1);
  localparam logic [CNT_W-1:0] LAST_AT  = CNT_W'(CTRL_W + RES_W);

  logic [RES_W-1:0] res;

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
      strobe  <= 1'b0;
    end else if (cs_n) begin
      dout    <= 1'b0;
      dout_oe <= 1'b0;
      strobe  <= 1'b0;
    end else begin
      dout_oe <= 1'b1;
      if (load) begin
        res <= load_data;
      end else if (fall) begin
        strobe <= (cnt == STB_AT);
        if (cnt >= FIRST_AT && cnt <= LAST_AT) begin
          dout <= res[RES_W-1];
          res  <= {res[RES_W-2:0], 1'b0};
        end else begin
          dout <= 1'b0;
        end
      end
    end
  end

  // R3
  dout_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> $past(fall || cs_n));

  // R3
  strobe_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(strobe) |-> $past(fall || cs_n));

  // R4
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |-> !dout);
endmodule

// File: rtl/sadc_port.sv
module sadc_port
  import sadc_pkg::*;
#(
  parameter int P_RES_W  = RES_W,
  parameter int P_NUM_CH = NUM_CH,
  parameter int P_CTRL_W = CTRL_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cs_n,
  input  logic                         sclk,
  input  logic                         din,
  input  logic [P_NUM_CH*P_RES_W-1:0]  chan_samples,
  output logic                         dout,
  output logic                         dout_oe,
  output logic                         strobe
);
  localparam int CH_W  = (P_NUM_CH > 1) ? $clog2(P_NUM_CH) : 1;
  localparam int CNT_W = $clog2(P_CTRL_W + P_RES_W + 2);

  logic             sclk_q;
  logic             rise, fall;
  logic             active, load;
  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  chan;
  logic [P_RES_W-1:0] picked;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk;
  end

  assign rise = !cs_n && sclk && !sclk_q;
  assign fall = !cs_n && !sclk && sclk_q;

  sadc_framer #(.CTRL_W(P_CTRL_W), .CH_W(CH_W), .CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rise(rise), .din(din),
    .active(active), .cnt(cnt), .load(load), .chan(chan)
  );

  sadc_mux #(.NUM_CH(P_NUM_CH), .RES_W(P_RES_W), .CH_W(CH_W)) u_mux (
    .bus(chan_samples), .chan(chan), .sel(picked)
  );

  sadc_tx #(.RES_W(P_RES_W), .CTRL_W(P_CTRL_W), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .cs_n(cs_n), .fall(fall), .load(load),
    .load_data(picked), .cnt(cnt), .dout(dout), .dout_oe(dout_oe),
    .strobe(strobe)
  );

  // R9
  deselect_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!strobe && !dout_oe));

  // R1
  idle_frame_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !active);
endmodule

// File: tb/sadc_port_bench.sv
module sadc_port_bench;
  localparam int RW = 10;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic [NC*RW-1:0] samples = '0;
  logic dout, dout_oe, strobe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sadc_port u_sadc_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .chan_samples(samples), .dout(dout), .dout_oe(dout_oe), .strobe(strobe)
  );

  // [31:28] leading zeros, [27:20] control byte, [9:0] sample
  localparam logic [31:0] VEC [8] = '{
    {4'd0, 8'hFF, 10'd0, 10'h2A5},
    {4'd0, 8'h80, 10'd0, 10'h3FF},
    {4'd3, 8'h9F, 10'd0, 10'h001},
    {4'd1, 8'hA0, 10'd0, 10'h200},
    {4'd5, 8'hB3, 10'd0, 10'h155},
    {4'd2, 8'hC8, 10'd0, 10'h0F0},
    {4'd7, 8'hD1, 10'd0, 10'h30C},
    {4'd4, 8'hE6, 10'd0, 10'h1E7}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_clk(input logic b, output logic d, output logic s,
                         output logic ok);
    @(negedge clk) din = b;
    repeat (3) @(negedge clk);
    d = dout;
    s = strobe;
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    ok = (dout == d) && (strobe == s);
    repeat (2) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic frame(input int lead, input logic [7:0] ctrl,
                       input logic [RW-1:0] exp_val, input int new_val);
    logic d, s, ok;
    logic [7:0] b2, b3;
    int stb_bad, stb_hits, stable_bad;
    stb_bad = 0; stb_hits = 0; stable_bad = 0;
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < lead; i++) bit_clk(1'b0, d, s, ok);
    for (int i = 7; i >= 0; i--) begin
      bit_clk(ctrl[i], d, s, ok);
      if (s) stb_bad++;
      if (!ok) stable_bad++;
    end
    if (new_val >= 0)
      samples[ctrl[6:4]*RW +: RW] = RW'(new_val);
    for (int k = 9; k <= 24; k++) begin
      bit_clk(1'b0, d, s, ok);
      if (!ok) stable_bad++;
      if (s) begin
        stb_hits++;
        if (k != 9) stb_bad++;
      end
      if (k <= 16) b2[16-k] = d;
      else         b3[24-k] = d;
    end
    // R7 R5 R6 byte layout of the result
    check("R7/R5/R6 second byte", b2, {1'b0, exp_val[9:3]});
    check("R7/R5 third byte", b3, {exp_val[2:0], 5'b0});
    // R4 strobe only at rising edge 9
    check("R4 strobe position", stb_bad * 100 + stb_hits, 1);
    // R3 outputs steady across rising edges
    check("R3 stable at rise", stable_bad, 0);
    bit_clk(1'b0, d, s, ok);
    bit_clk(1'b0, d, s, ok);
    // R8 low after LSB
    check("R8 dout low tail", {dout_oe, dout}, 2'b10);
    @(negedge clk) cs_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 deselected outputs
    check("R9 deselected", {dout_oe, strobe}, 2'b00);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic d, s, ok;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 reset outputs", {dout_oe, strobe, dout}, 3'b000);

    for (int v = 0; v < 8; v++) begin
      for (int c = 0; c < NC; c++) samples[c*RW +: RW] = RW'($urandom);
      samples[VEC[v][26:24]*RW +: RW] = VEC[v][9:0];
      // R2 leading zeros, R6 channel field, R12 0xFF selects channel 7
      frame(int'(VEC[v][31:28]), VEC[v][27:20], VEC[v][9:0], -1);
    end

    // R1: clocking ones while deselected must not start a frame
    for (int i = 0; i < 6; i++) bit_clk(1'b1, d, s, ok);
    check("R1 idle clocks ignored", {dout_oe, strobe}, 2'b00);
    samples[2*RW +: RW] = 10'h2C3;
    frame(0, 8'hA5, 10'h2C3, -1);

    // R10: abort after four control bits, then a clean frame
    samples[1*RW +: RW] = 10'h111;
    samples[6*RW +: RW] = 10'h3A9;
    @(negedge clk) cs_n = 1'b0;
    bit_clk(1'b1, d, s, ok);
    bit_clk(1'b1, d, s, ok);
    bit_clk(1'b1, d, s, ok);
    bit_clk(1'b0, d, s, ok);
    @(negedge clk) cs_n = 1'b1;
    repeat (3) @(negedge clk);
    frame(2, 8'h9C, 10'h111, -1);

    // R11: change the sample after the control byte
    samples[5*RW +: RW] = 10'h0C5;
    frame(1, 8'hD0, 10'h0C5, 10'h33A);

    // R12 all-ones byte, explicit
    samples[7*RW +: RW] = 10'h1B2;
    samples[0 +: RW] = 10'h001;
    frame(0, 8'hFF, 10'h1B2, -1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule